// File: doc/BRIEF.md
# Banked interrupt-interface control register

This block holds the 64-bit control and feature word of the CPU side of an interrupt interface. The word has two parts. Feature flags and codes are read-only and are fixed by parameters, so software can find out what the interface supports. Three control bits are writable: the priority-mask hint enable, the end-of-interrupt mode and the common binary point select. These control bits exist twice, once for the Secure state and once for the Non-secure state. The `ns_i` input picks which copy a read returns and which copy a write updates.

Access is through a plain register port made of a select, a write enable, 64-bit write data and 64-bit read data. Reads are combinational, so the selected bank shows up in the same cycle as the access. Writes take effect at the next clock edge. The global `dis_sec_i` input controls whether the hint enable can be written. When the highest privilege level is built in, it also controls whether the common binary point bit can be written. The logic that acts on these bits (priority masking, preemption and deactivation) lives outside this block.

Top module: `ctl_reg`

## Requirements
- R1: Bits 63:20, 17:16, 7 and 5:2 always read as 0, and writing ones to them has no effect.
- R2: The read-only flags come from parameters and ignore writes. Bit 19 is the extended ID range flag (`EXT_ID_EN`), bit 18 is the range selector flag (`RANGE_SEL_EN`), bit 15 is the non-zero affinity-3 flag (`AFF3_EN`) and bit 14 is the local error-interrupt flag (`LERR_EN`).
- R3: Bits 13:11 return the `ID_CODE` parameter, where 0 means 16-bit IDs and 1 means 24-bit IDs. Bits 10:8 return `PRIO_BITS`-1. Writes do not change either field.
- R4: A write always loads bit 1, the end-of-interrupt mode, into the selected bank.
- R5: A write loads bit 6, the priority-mask hint enable, only when `dis_sec_i`=1. When `dis_sec_i`=0 the stored bit is kept.
- R6: With `TOP_LVL`=1, a write loads bit 0, the common binary point select, only when `dis_sec_i`=1. With `TOP_LVL`=0, bit 0 is always writable.
- R7: `ns_i`=0 selects the Secure bank and `ns_i`=1 selects the Non-secure bank. A write never changes the bank that is not selected.
- R8: While `sel_i`=1, `rdata_o` shows the bank chosen by `ns_i` in the same cycle, with no register stage. While `sel_i`=0, `rdata_o` is 0.
- R9: Reset, which is asynchronous and active low, clears bits 6, 1 and 0 in both banks.
- R10: A write happens only when `sel_i`=1 and `we_i`=1 at a rising clock edge. Any other combination leaves both banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access select |
| we_i | input | 1 | Write enable, qualified by sel_i |
| ns_i | input | 1 | Security state: 0 Secure, 1 Non-secure |
| dis_sec_i | input | 1 | Global disable-security; 1 unlocks bits 6 and 0 |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data of the selected bank |

## Verification
The bench builds two copies of the block and drives both with the same stimulus. One copy has the highest privilege level present, 24-bit IDs, 5 priority bits, and the extended-range and affinity-3 flags set. The other has no highest privilege level, 16-bit IDs, 4 priority bits, and the range-selector and error-interrupt flags set. With these two builds, every feature flag is seen at both 0 and 1. They also cover both rules for bit 0: the same write with `dis_sec_i`=0 leaves bit 0 alone in the first copy and loads it in the second.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int unsigned DW       = 64;
  localparam int unsigned NCTL     = 3;
  localparam int unsigned NBANK    = 2;
  // control bit index inside a bank
  localparam int unsigned IDX_CBPR = 0;
  localparam int unsigned IDX_EOI  = 1;
  localparam int unsigned IDX_HINT = 2;
  // word bit positions
  localparam int unsigned POS_CBPR = 0;
  localparam int unsigned POS_EOI  = 1;
  localparam int unsigned POS_HINT = 6;
  localparam int unsigned POS_PRI  = 8;
  localparam int unsigned POS_ID   = 11;
  localparam int unsigned POS_LERR = 14;
  localparam int unsigned POS_AFF3 = 15;
  localparam int unsigned POS_RSEL = 18;
  localparam int unsigned POS_EXT  = 19;
  localparam int unsigned FLD_W    = 3;

  localparam logic [DW-1:0] USED_M =
      (64'h1 << POS_CBPR) | (64'h1 << POS_EOI) | (64'h1 << POS_HINT) |
      (64'h7 << POS_PRI)  | (64'h7 << POS_ID)  | (64'h1 << POS_LERR) |
      (64'h1 << POS_AFF3) | (64'h1 << POS_RSEL) | (64'h1 << POS_EXT);
  localparam logic [DW-1:0] RSVD_M = ~USED_M;

  typedef logic [NCTL-1:0] ctl_bits_t;
endpackage

// File: rtl/ctl_feat.sv
module ctl_feat
  import ctl_pkg::*;
#(
  parameter bit          EXT_ID_EN    = 1'b1,
  parameter bit          RANGE_SEL_EN = 1'b0,
  parameter bit          AFF3_EN      = 1'b1,
  parameter bit          LERR_EN      = 1'b0,
  parameter logic [2:0]  ID_CODE      = 3'd1,
  parameter int unsigned PRIO_BITS    = 5
) (
  output logic [DW-1:0] feat_o
);
  localparam logic [FLD_W-1:0] PRI_FLD = FLD_W'(PRIO_BITS - 1);

  always_comb begin
    feat_o = '0;
    feat_o[POS_EXT]                 = EXT_ID_EN;
    feat_o[POS_RSEL]                = RANGE_SEL_EN;
    feat_o[POS_AFF3]                = AFF3_EN;
    feat_o[POS_LERR]                = LERR_EN;
    feat_o[POS_ID +: FLD_W]         = ID_CODE;
    feat_o[POS_PRI +: FLD_W]        = PRI_FLD;
  end
endmodule

// File: rtl/ctl_bank.sv
module ctl_bank
  import ctl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  ctl_bits_t wmask_i,
  input  ctl_bits_t wdata_i,
  output ctl_bits_t q_o
);
  ctl_bits_t q_q;

  for (genvar i = 0; i < NCTL; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   q_q[i] <= 1'b0;
      else if (wr_i && wmask_i[i])   q_q[i] <= wdata_i[i];
    end

    // R5 / R6: a masked bit keeps its value across a write
    a_r5_masked_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !wmask_i[i]) |=> $stable(q_q[i]));
    a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && wmask_i[i]) |=> (q_q[i] == $past(wdata_i[i])));
  end

  assign q_o = q_q;

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_q));
endmodule

// File: rtl/ctl_reg.sv
module ctl_reg
  import ctl_pkg::*;
#(
  parameter bit          TOP_LVL      = 1'b1,
  parameter bit          EXT_ID_EN    = 1'b1,
  parameter bit          RANGE_SEL_EN = 1'b0,
  parameter bit          AFF3_EN      = 1'b1,
  parameter bit          LERR_EN      = 1'b0,
  parameter logic [2:0]  ID_CODE      = 3'd1,
  parameter int unsigned PRIO_BITS    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic          ns_i,
  input  logic          dis_sec_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] feat;
  ctl_bits_t     wmask, wbits, rbits;
  ctl_bits_t     bank_q [NBANK];
  logic [NBANK-1:0] bank_wr;
  logic [DW-1:0] word;
  logic          unused_wd;

  assign unused_wd = ^{wdata_i[DW-1:POS_HINT+1], wdata_i[POS_HINT-1:POS_EOI+1]};

  ctl_feat #(
    .EXT_ID_EN   (EXT_ID_EN),
    .RANGE_SEL_EN(RANGE_SEL_EN),
    .AFF3_EN     (AFF3_EN),
    .LERR_EN     (LERR_EN),
    .ID_CODE     (ID_CODE),
    .PRIO_BITS   (PRIO_BITS)
  ) u_feat (
    .feat_o(feat)
  );

  always_comb begin
    wbits           = '0;
    wbits[IDX_HINT] = wdata_i[POS_HINT];
    wbits[IDX_EOI]  = wdata_i[POS_EOI];
    wbits[IDX_CBPR] = wdata_i[POS_CBPR];
    wmask           = '0;
    wmask[IDX_HINT] = dis_sec_i;
    wmask[IDX_EOI]  = 1'b1;
    wmask[IDX_CBPR] = TOP_LVL ? dis_sec_i : 1'b1;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_wr[b] = sel_i && we_i && (ns_i == b[0]);
    ctl_bank u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (bank_wr[b]),
      .wmask_i(wmask),
      .wdata_i(wbits),
      .q_o    (bank_q[b])
    );
  end

  assign rbits = ns_i ? bank_q[1] : bank_q[0];

  always_comb begin
    word           = feat;
    word[POS_HINT] = rbits[IDX_HINT];
    word[POS_EOI]  = rbits[IDX_EOI];
    word[POS_CBPR] = rbits[IDX_CBPR];
  end

  assign rdata_o = sel_i ? word : '0;

  a_r1_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & RSVD_M) == '0);
  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> (rdata_o == '0));
  a_r7_sec_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && ns_i) |=> $stable(bank_q[0]));
  a_r7_nsec_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && !ns_i) |=> $stable(bank_q[1]));
  a_r5_hint_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && !dis_sec_i) |=>
      ($stable(bank_q[0][IDX_HINT]) && $stable(bank_q[1][IDX_HINT])));
  a_r2_feat_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && $past(sel_i)) |-> $stable(rdata_o & ~(RSVD_M |
      (64'h1 << POS_HINT) | (64'h1 << POS_EOI) | (64'h1 << POS_CBPR))));
endmodule

// File: tb/sim_ctl_reg.sv
module sim_ctl_reg;
  localparam int unsigned DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0, ns = 1'b0, dis = 1'b0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rd0, rd1;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ctl_reg #(.TOP_LVL(1'b1), .EXT_ID_EN(1'b1), .RANGE_SEL_EN(1'b0), .AFF3_EN(1'b1),
            .LERR_EN(1'b0), .ID_CODE(3'd1), .PRIO_BITS(5)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .ns_i(ns),
    .dis_sec_i(dis), .wdata_i(wd), .rdata_o(rd0));

  ctl_reg #(.TOP_LVL(1'b0), .EXT_ID_EN(1'b0), .RANGE_SEL_EN(1'b1), .AFF3_EN(1'b0),
            .LERR_EN(1'b1), .ID_CODE(3'd0), .PRIO_BITS(4)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .ns_i(ns),
    .dis_sec_i(dis), .wdata_i(wd), .rdata_o(rd1));

  // R2 R3: bits 19,18,15,14 flags; 13:11 id code; 10:8 prio bits - 1
  localparam logic [DW-1:0] FEAT0 = (64'h1 << 19) | (64'h1 << 15) | (64'h1 << 11) | (64'h4 << 8);
  localparam logic [DW-1:0] FEAT1 = (64'h1 << 18) | (64'h1 << 14) | (64'h0 << 11) | (64'h3 << 8);

  // model bits: [2]=hint(bit 6) [1]=eoi(bit 1) [0]=cbpr(bit 0)
  logic [2:0] m0 [2];
  logic [2:0] m1 [2];

  typedef struct packed {
    logic          sel;
    logic          we;
    logic          ns;
    logic          dis;
    logic [DW-1:0] wd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 1'b0, 1'b1, 64'h43},
    '{1'b1, 1'b1, 1'b1, 1'b0, 64'h43},
    '{1'b1, 1'b1, 1'b0, 1'b0, 64'h00},
    '{1'b1, 1'b1, 1'b1, 1'b1, 64'h41},
    '{1'b0, 1'b1, 1'b0, 1'b1, 64'h00},
    '{1'b1, 1'b0, 1'b1, 1'b1, 64'h00},
    '{1'b1, 1'b1, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
    '{1'b1, 1'b1, 1'b1, 1'b1, 64'h02}
  };

  function automatic logic [DW-1:0] mk(input logic [DW-1:0] f, input logic [2:0] b);
    mk = f | (DW'(b[2]) << 6) | (DW'(b[1]) << 1) | DW'(b[0]);
  endfunction

  function automatic logic [2:0] upd(input logic [2:0] b, input vec_t v, input bit top);
    logic [2:0] n;
    n = b;
    n[1] = v.wd[1];
    if (v.dis) n[2] = v.wd[6];
    if (!top || v.dis) n[0] = v.wd[0];
    upd = n;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic read_both(input string tag);
    @(negedge clk);
    sel = 1'b1; we = 1'b0;
    for (int b = 0; b < 2; b++) begin
      ns = b[0];
      #1;
      check({tag, " u0"}, rd0, mk(FEAT0, m0[b]));
      check({tag, " u1"}, rd1, mk(FEAT1, m1[b]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) begin m0[b] = '0; m1[b] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9 reset state, R2 R3 feature fields
    read_both("R9 R2 R3 reset");

    // R8 idle read is zero
    sel = 1'b0; #1;
    check("R8 idle u0", rd0, '0);
    check("R8 idle u1", rd1, '0);

    // vector walk: R4 R5 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sel = VEC[i].sel; we = VEC[i].we; ns = VEC[i].ns; dis = VEC[i].dis; wd = VEC[i].wd;
      @(posedge clk);
      if (VEC[i].sel && VEC[i].we) begin
        m0[VEC[i].ns] = upd(m0[VEC[i].ns], VEC[i], 1'b1);
        m1[VEC[i].ns] = upd(m1[VEC[i].ns], VEC[i], 1'b0);
      end
      read_both("R4 R5 R6 R7 R10 vec");
    end

    // R1 reserved bits stay zero after all-ones write
    @(negedge clk);
    ns = 1'b1; #1;
    check("R1 rsvd u0", rd0 & ~(64'hC_CFFF & 64'hC_CF43 | FEAT0 | 64'h43), '0);

    // R6 top-level lock: cbpr write with dis=0 differs between builds
    @(negedge clk);
    sel = 1'b1; we = 1'b1; ns = 1'b1; dis = 1'b0; wd = 64'h01;
    @(posedge clk);
    m1[1][0] = 1'b1; m1[1][1] = 1'b0; m0[1][1] = 1'b0;
    read_both("R6 cbpr lock");

    // R8 same-cycle bank switch without a clock edge
    @(negedge clk);
    sel = 1'b1; we = 1'b0; ns = 1'b0; #0.5;
    check("R8 switch s", rd0, mk(FEAT0, m0[0]));
    ns = 1'b1; #0.5;
    check("R8 switch ns", rd0, mk(FEAT0, m0[1]));

    // R9 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0; #1;
    for (int b = 0; b < 2; b++) begin m0[b] = '0; m1[b] = '0; end
    sel = 1'b1; ns = 1'b0; #0.5;
    check("R9 async u0", rd0, FEAT0);
    check("R9 async u1", rd1, FEAT1);
    @(negedge clk) rst_n = 1'b1;
    read_both("R9 after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule